// File: doc/BRIEF.md
# PLL Output Frequency Calculator

This unit turns a PLL parameter word, a clock-select word and a set of strap inputs into two integer frequencies in hertz. One is the main PLL output and the other is the APB bus clock derived from it. A start strobe latches the inputs. The block then runs three truncating integer divisions in turn on one shared iterative divider. It presents both results together with a one-cycle done strobe and holds them until the next calculation finishes.

Three field layouts are supported, chosen by a parameter: an oldest, a middle and a newer variant. A second parameter makes the reference clock always 25 MHz, and a third sets the fixed APB ratio of 2 or 4. The positions of the control bits in the parameter word and of the strap bits are parameters as well. The defaults are used throughout this brief.

Top module: `pllfreq_calc`

## Requirements
- R1: The reference clock is 25 MHz when strap bit 23 is 1 or the force-25 MHz parameter is set. Otherwise it is 48 MHz when strap bit 18 is 1, and otherwise 24 MHz.
- R2: When bit 23 of the parameter word (off) is 1, both pll_hz and apb_hz report 0.
- R3: When bit 24 (bypass) is 1, pll_hz equals the reference clock and the divider fields are ignored. On the oldest variant this applies only when bit 25 (programmed) is also 1.
- R4: Newer variant: M = word[12:0], N = word[18:13], P = word[22:19]. pll_hz = ref * (((M+1)/(N+1))/(P+1)), with each division truncating.
- R5: Middle variant: N = word[4:0], M = word[12:5], P = word[18:13]. The formula is the same as in R4, with the same truncation.
- R6: Oldest variant with bit 25 = 1 and bit 24 = 0: D = word[3:0], OD = word[4], N = word[10:5]. pll_hz = ref * (2-OD) * ((N+2)/(D+1)), truncating.
- R7: Oldest variant with bit 25 = 0: pll_hz is a table value in MHz times 10^6. The table index is strap[9:8]. With strap bit 23 = 0, indices 0..3 give 384, 360, 336 and 408. With strap bit 23 = 1 they give 400, 375, 350 and 425.
- R8: apb_hz = pll_hz / ((S+1) * ratio), truncating, where S = clk_sel[25:23] and ratio is the APB ratio parameter.
- R9: done is high for exactly one cycle, 3*FREQ_W+6 rising edges after the edge that accepts start (126 with defaults). That is one cycle after the last divider step.
- R10: pll_hz and apb_hz change only in the cycle done is high. A start that arrives before done has been raised is ignored and does not alter the result.
- R11: After reset, pll_hz, apb_hz and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Latch inputs and begin a calculation when idle |
| pll_word | input | 32 | PLL parameter word |
| clk_sel | input | 32 | Clock-select word holding the APB divider field |
| strap | input | 32 | Strap inputs (reference and table index bits) |
| pll_hz | output | FREQ_W (40) | PLL output frequency in Hz |
| apb_hz | output | FREQ_W (40) | APB frequency in Hz |
| done | output | 1 | One-cycle strobe marking new results |

## Verification
Two situations are hard to reach from the ports. The first is a start pulse that lands while a calculation is still in progress. The bench raises start partway through a calculation with a different parameter word and expects the first result to come through unchanged. The second is the oldest variant's strap table and its 48 MHz reference, which the other variants never use. The bench instantiates all three configurations side by side on the same inputs, so every stimulus is checked against each layout. A behavioural model tracks the expected outputs for every lane on every clock.

// File: rtl/pllfreq_pkg.sv
package pllfreq_pkg;

  localparam int OPW = 16;

  localparam int VAR_OLD = 0;
  localparam int VAR_MID = 1;
  localparam int VAR_NEW = 2;

  localparam logic [25:0] REF_24M = 26'd24_000_000;
  localparam logic [25:0] REF_25M = 26'd25_000_000;
  localparam logic [25:0] REF_48M = 26'd48_000_000;

  // Operands for the two multiplier divisions plus the path flags
  typedef struct packed {
    logic           off;
    logic           use_table;
    logic [8:0]     tbl_mhz;
    logic [OPW-1:0] num1;
    logic [OPW-1:0] den1;
    logic [OPW-1:0] den2;
    logic [1:0]     scale;
  } plan_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE1,
    ST_WAIT1,
    ST_ISSUE2,
    ST_WAIT2,
    ST_ISSUE3,
    ST_WAIT3
  } seq_t;

  function automatic logic [25:0] pick_ref(logic s25, logic s48, logic force25);
    if (s25 || force25) return REF_25M;
    if (s48)            return REF_48M;
    return REF_24M;
  endfunction

  function automatic logic [8:0] table_mhz(logic row25, logic [1:0] idx);
    logic [8:0] t;
    unique case ({row25, idx})
      3'b000:  t = 9'd384;
      3'b001:  t = 9'd360;
      3'b010:  t = 9'd336;
      3'b011:  t = 9'd408;
      3'b100:  t = 9'd400;
      3'b101:  t = 9'd375;
      3'b110:  t = 9'd350;
      default: t = 9'd425;
    endcase
    return t;
  endfunction

  function automatic logic [63:0] scaled_freq(logic [25:0] r, logic [63:0] q, logic [1:0] k);
    return 64'(r) * q * 64'(k);
  endfunction

endpackage

// File: rtl/pllfreq_refsel.sv
module pllfreq_refsel
  import pllfreq_pkg::*;
#(
  parameter int FORCE_25M = 1
) (
  input  logic        s25,
  input  logic        s48,
  output logic [25:0] ref_hz
);

  localparam logic FORCE_BIT = (FORCE_25M != 0);

  assign ref_hz = pick_ref(s25, s48, FORCE_BIT);

endmodule

// File: rtl/pllfreq_decode.sv
module pllfreq_decode
  import pllfreq_pkg::*;
#(
  parameter int VARIANT  = VAR_NEW,
  parameter int WORD_W   = 32,
  parameter int OFF_BIT  = 23,
  parameter int BYP_BIT  = 24,
  parameter int PROG_BIT = 25
) (
  input  logic [WORD_W-1:0] word,
  input  logic              s25,
  input  logic [1:0]        tbl_idx,
  output plan_t             plan
);

  logic unused_in;
  assign unused_in = ^{word, s25, tbl_idx};

  generate
    if (VARIANT == VAR_NEW) begin : g_new
      always_comb begin
        plan       = '0;
        plan.off   = word[OFF_BIT];
        plan.scale = 2'd1;
        if (word[BYP_BIT]) begin
          plan.num1 = OPW'(1);
          plan.den1 = OPW'(1);
          plan.den2 = OPW'(1);
        end else begin
          plan.num1 = OPW'(word[12:0]) + OPW'(1);
          plan.den1 = OPW'(word[18:13]) + OPW'(1);
          plan.den2 = OPW'(word[22:19]) + OPW'(1);
        end
      end
    end else if (VARIANT == VAR_MID) begin : g_mid
      always_comb begin
        plan       = '0;
        plan.off   = word[OFF_BIT];
        plan.scale = 2'd1;
        if (word[BYP_BIT]) begin
          plan.num1 = OPW'(1);
          plan.den1 = OPW'(1);
          plan.den2 = OPW'(1);
        end else begin
          plan.num1 = OPW'(word[12:5]) + OPW'(1);
          plan.den1 = OPW'(word[4:0]) + OPW'(1);
          plan.den2 = OPW'(word[18:13]) + OPW'(1);
        end
      end
    end else begin : g_old
      always_comb begin
        plan       = '0;
        plan.off   = word[OFF_BIT];
        plan.scale = 2'd1;
        plan.num1  = OPW'(1);
        plan.den1  = OPW'(1);
        plan.den2  = OPW'(1);
        if (!word[PROG_BIT]) begin
          plan.use_table = 1'b1;
          plan.tbl_mhz   = table_mhz(s25, tbl_idx);
        end else if (!word[BYP_BIT]) begin
          plan.num1  = OPW'(word[10:5]) + OPW'(2);
          plan.den1  = OPW'(word[3:0]) + OPW'(1);
          plan.scale = word[4] ? 2'd1 : 2'd2;
        end
      end
    end
  endgenerate

endmodule

// File: rtl/pllfreq_divider.sv
module pllfreq_divider #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic         fin
);

  localparam int CW = $clog2(W + 1);

  logic          busy;
  logic [CW-1:0] left;
  logic [W-1:0]  rem;
  logic [W-1:0]  quo;
  logic [W-1:0]  dvs;
  logic [W:0]    trial;
  logic          fits;
  logic          last_step;

  assign trial     = {rem, quo[W-1]};
  assign fits      = trial >= {1'b0, dvs};
  assign last_step = busy && (left == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      left <= '0;
      rem  <= '0;
      quo  <= '0;
      dvs  <= '0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go && !busy) begin
        busy <= 1'b1;
        left <= CW'(W);
        rem  <= '0;
        quo  <= dividend;
        dvs  <= divisor;
      end else if (busy) begin
        rem  <= fits ? W'(trial - {1'b0, dvs}) : trial[W-1:0];
        quo  <= {quo[W-2:0], fits};
        left <= left - 1'b1;
        if (last_step) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo;

  AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> (divisor != '0)); // R4
  AST_DIV_GO_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy); // R9
  AST_DIV_FIN_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> !fin); // R9

endmodule

// File: rtl/pllfreq_calc.sv
module pllfreq_calc
  import pllfreq_pkg::*;
#(
  parameter int VARIANT   = VAR_NEW,
  parameter int FORCE_25M = 1,
  parameter int APB_RATIO = 4,
  parameter int FREQ_W    = 40,
  parameter int WORD_W    = 32,
  parameter int SEL_W     = 32,
  parameter int STRAP_W   = 32,
  parameter int OFF_BIT   = 23,
  parameter int BYP_BIT   = 24,
  parameter int PROG_BIT  = 25,
  parameter int PCLK_LSB  = 23,
  parameter int PCLK_W    = 3,
  parameter int S25_BIT   = 23,
  parameter int S48_BIT   = 18,
  parameter int TBL_LSB   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] pll_word,
  input  logic [SEL_W-1:0]  clk_sel,
  input  logic [STRAP_W-1:0] strap,
  output logic [FREQ_W-1:0] pll_hz,
  output logic [FREQ_W-1:0] apb_hz,
  output logic              done
);

  localparam logic [FREQ_W-1:0] ONE_F = FREQ_W'(1);

  seq_t               st;
  plan_t              plan_d;
  plan_t              plan_q;
  logic [25:0]        ref_d;
  logic [25:0]        ref_q;
  logic [PCLK_W-1:0]  pclk_q;
  logic [FREQ_W-1:0]  q1_q;
  logic [FREQ_W-1:0]  pll_q;
  logic [FREQ_W-1:0]  pll_calc;
  logic [FREQ_W-1:0]  apb_den;
  logic [FREQ_W-1:0]  div_a;
  logic [FREQ_W-1:0]  div_b;
  logic [FREQ_W-1:0]  div_q;
  logic               div_go;
  logic               div_fin;

  // Named internal events
  logic accept_start;
  logic got_q1;
  logic got_q2;
  logic got_q3;

  logic unused_inputs;
  assign unused_inputs = ^{strap, clk_sel};

  assign accept_start = (st == ST_IDLE) && start;
  assign got_q1       = (st == ST_WAIT1) && div_fin;
  assign got_q2       = (st == ST_WAIT2) && div_fin;
  assign got_q3       = (st == ST_WAIT3) && div_fin;
  assign div_go       = (st == ST_ISSUE1) || (st == ST_ISSUE2) || (st == ST_ISSUE3);

  pllfreq_refsel #(
    .FORCE_25M(FORCE_25M)
  ) u_refsel (
    .s25    (strap[S25_BIT]),
    .s48    (strap[S48_BIT]),
    .ref_hz (ref_d)
  );

  pllfreq_decode #(
    .VARIANT  (VARIANT),
    .WORD_W   (WORD_W),
    .OFF_BIT  (OFF_BIT),
    .BYP_BIT  (BYP_BIT),
    .PROG_BIT (PROG_BIT)
  ) u_decode (
    .word    (pll_word),
    .s25     (strap[S25_BIT]),
    .tbl_idx (strap[TBL_LSB +: 2]),
    .plan    (plan_d)
  );

  assign apb_den = FREQ_W'((32'(pclk_q) + 32'd1) * 32'(APB_RATIO));

  always_comb begin
    div_a = '0;
    div_b = ONE_F;
    unique case (st)
      ST_ISSUE1: begin
        div_a = FREQ_W'(plan_q.num1);
        div_b = FREQ_W'(plan_q.den1);
      end
      ST_ISSUE2: begin
        div_a = q1_q;
        div_b = FREQ_W'(plan_q.den2);
      end
      ST_ISSUE3: begin
        div_a = pll_q;
        div_b = apb_den;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (plan_q.off) begin
      pll_calc = '0;
    end else if (plan_q.use_table) begin
      pll_calc = FREQ_W'(64'(plan_q.tbl_mhz) * 64'd1_000_000);
    end else begin
      pll_calc = FREQ_W'(scaled_freq(ref_q, 64'(div_q), plan_q.scale));
    end
  end

  pllfreq_divider #(
    .W(FREQ_W)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (div_go),
    .dividend (div_a),
    .divisor  (div_b),
    .quotient (div_q),
    .fin      (div_fin)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      plan_q <= '0;
      ref_q  <= '0;
      pclk_q <= '0;
      q1_q   <= '0;
      pll_q  <= '0;
      pll_hz <= '0;
      apb_hz <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (accept_start) begin
          plan_q <= plan_d;
          ref_q  <= ref_d;
          pclk_q <= clk_sel[PCLK_LSB +: PCLK_W];
          st     <= ST_ISSUE1;
        end
        ST_ISSUE1: st <= ST_WAIT1;
        ST_WAIT1: if (got_q1) begin
          q1_q <= div_q;
          st   <= ST_ISSUE2;
        end
        ST_ISSUE2: st <= ST_WAIT2;
        ST_WAIT2: if (got_q2) begin
          pll_q <= pll_calc;
          st    <= ST_ISSUE3;
        end
        ST_ISSUE3: st <= ST_WAIT3;
        ST_WAIT3: if (got_q3) begin
          pll_hz <= pll_q;
          apb_hz <= div_q;
          done   <= 1'b1;
          st     <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_REF_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_start && (strap[S25_BIT] || (FORCE_25M != 0))) |=> (ref_q == REF_25M)); // R1
  AST_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && plan_q.off) |-> (pll_hz == '0 && apb_hz == '0)); // R2
  AST_APB_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (apb_hz <= pll_hz)); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    got_q3 |=> done); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_HOLD_PLL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pll_hz) |-> done); // R10
  AST_HOLD_APB: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(apb_hz) |-> done); // R10
  AST_BUSY_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ((st != ST_IDLE) && start) |=> $stable(plan_q)); // R10

endmodule

// File: tb/pllfreq_calc_bench.sv
module pllfreq_calc_bench;

  localparam int FW  = 40;
  localparam int LAT = 3 * FW + 6;
  localparam int NL  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] pword = '0;
  logic [31:0] csel = '0;
  logic [31:0] strap = '0;

  logic [FW-1:0] pll_o [NL];
  logic [FW-1:0] apb_o [NL];
  logic          done_o [NL];

  // lane 0: newer, forced 25 MHz, ratio 4; lane 1: middle, ratio 4; lane 2: oldest, ratio 2
  int lane_var   [NL] = '{2, 1, 0};
  bit lane_f25   [NL] = '{1'b1, 1'b0, 1'b0};
  int lane_ratio [NL] = '{4, 4, 2};

  int    n_chk = 0;
  int    n_fail = 0;
  string cur_tag = "R11";

  always #2 clk = ~clk;

  pllfreq_calc #(.VARIANT(2), .FORCE_25M(1), .APB_RATIO(4), .FREQ_W(FW)) u_pllfreq_calc (
    .clk(clk), .rst_n(rst_n), .start(start), .pll_word(pword), .clk_sel(csel), .strap(strap),
    .pll_hz(pll_o[0]), .apb_hz(apb_o[0]), .done(done_o[0]));

  pllfreq_calc #(.VARIANT(1), .FORCE_25M(0), .APB_RATIO(4), .FREQ_W(FW)) u_pllfreq_calc_mid (
    .clk(clk), .rst_n(rst_n), .start(start), .pll_word(pword), .clk_sel(csel), .strap(strap),
    .pll_hz(pll_o[1]), .apb_hz(apb_o[1]), .done(done_o[1]));

  pllfreq_calc #(.VARIANT(0), .FORCE_25M(0), .APB_RATIO(2), .FREQ_W(FW)) u_pllfreq_calc_old (
    .clk(clk), .rst_n(rst_n), .start(start), .pll_word(pword), .clk_sel(csel), .strap(strap),
    .pll_hz(pll_o[2]), .apb_hz(apb_o[2]), .done(done_o[2]));

  function automatic longint ref_of(bit f25, logic [31:0] s);
    if (s[23] || f25) return 64'd25_000_000;
    if (s[18]) return 64'd48_000_000;
    return 64'd24_000_000;
  endfunction

  function automatic longint old_table(logic [31:0] s);
    longint mhz;
    case (s[9:8])
      2'd0:    mhz = s[23] ? 400 : 384;
      2'd1:    mhz = s[23] ? 375 : 360;
      2'd2:    mhz = s[23] ? 350 : 336;
      default: mhz = s[23] ? 425 : 408;
    endcase
    return mhz * 1_000_000;
  endfunction

  function automatic longint model_pll(int v, bit f25, logic [31:0] w, logic [31:0] s);
    longint r;
    longint a;
    longint b;
    longint c;
    r = ref_of(f25, s);
    if (w[23]) return 0;
    if (v == 0) begin
      if (!w[25]) return old_table(s);
      if (w[24]) return r;
      a = longint'(w[10:5]) + 2;
      b = longint'(w[3:0]) + 1;
      return r * (w[4] ? 1 : 2) * (a / b);
    end
    if (w[24]) return r;
    if (v == 1) begin
      a = longint'(w[12:5]) + 1;
      b = longint'(w[4:0]) + 1;
      c = longint'(w[18:13]) + 1;
    end else begin
      a = longint'(w[12:0]) + 1;
      b = longint'(w[18:13]) + 1;
      c = longint'(w[22:19]) + 1;
    end
    return r * ((a / b) / c);
  endfunction

  function automatic longint model_apb(longint p, logic [31:0] c, int ratio);
    return (p / (longint'(c[25:23]) + 1)) / ratio;
  endfunction

  // Behavioural reference model, advanced on every rising edge
  longint e_pll [NL];
  longint e_apb [NL];
  longint p_pll [NL];
  longint p_apb [NL];
  bit     e_done;
  int     cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt = 0;
      e_done = 1'b0;
      for (int l = 0; l < NL; l++) begin
        e_pll[l] = 0;
        e_apb[l] = 0;
      end
    end else if (cnt != 0) begin
      cnt = cnt - 1;
      e_done = (cnt == 0);
      if (cnt == 0) begin
        for (int l = 0; l < NL; l++) begin
          e_pll[l] = p_pll[l];
          e_apb[l] = p_apb[l];
        end
      end
    end else begin
      e_done = 1'b0;
      if (start) begin
        for (int l = 0; l < NL; l++) begin
          p_pll[l] = model_pll(lane_var[l], lane_f25[l], pword, strap);
          p_apb[l] = model_apb(p_pll[l], csel, lane_ratio[l]);
        end
        cnt = LAT;
      end
    end
  end

  task automatic chk(input string tag, input string what, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      for (int l = 0; l < NL; l++) begin
        chk(cur_tag, $sformatf("lane%0d done", l), longint'(done_o[l]), longint'(e_done));
        chk(cur_tag, $sformatf("lane%0d pll_hz", l), longint'(pll_o[l]), e_pll[l]);
        chk(cur_tag, $sformatf("lane%0d apb_hz", l), longint'(apb_o[l]), e_apb[l]);
      end
    end
  end

  task automatic run_op(input string tag, input logic [31:0] w, input logic [31:0] c,
                        input logic [31:0] s, output int lat);
    @(negedge clk);
    cur_tag = tag;
    pword = w;
    csel = c;
    strap = s;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done_o[0] && lat < 400) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired in %s", cur_tag);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lat;
    longint held;
    repeat (4) @(negedge clk);
    for (int l = 0; l < NL; l++) begin
      chk("R11", "reset pll_hz", longint'(pll_o[l]), 0);
      chk("R11", "reset apb_hz", longint'(apb_o[l]), 0);
      chk("R11", "reset done", longint'(done_o[l]), 0);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R4 newer layout: M=99 N=4 P=1 -> 10 x 25 MHz, S=1
    run_op("R4", 32'h0008_8063, 32'h1 << 23, 32'h0, lat);
    chk("R4", "newer pll", longint'(pll_o[0]), 250_000_000);
    chk("R8", "newer apb", longint'(apb_o[0]), 31_250_000);
    chk("R9", "latency", lat, LAT + 1);
    // R4 truncation: (11/3)/2 = 1
    run_op("R4", 32'h0008_400A, 32'h0, 32'h0, lat);
    chk("R4", "newer truncation", longint'(pll_o[0]), 25_000_000);

    // R5 middle layout: M=199 N=3 P=4 -> 10 x 48 MHz
    run_op("R5", 32'h0000_98E3, 32'h0, 32'h1 << 18, lat);
    chk("R5", "middle pll", longint'(pll_o[1]), 480_000_000);
    chk("R8", "middle apb", longint'(apb_o[1]), 120_000_000);

    // R6 oldest programmed: N=22 D=1 OD=0 -> 24 x 24 MHz, S=2
    run_op("R6", 32'h0200_02C1, 32'h2 << 23, 32'h0, lat);
    chk("R6", "oldest pll", longint'(pll_o[2]), 576_000_000);
    chk("R8", "oldest apb", longint'(apb_o[2]), 96_000_000);
    run_op("R6", 32'h0200_02D1, 32'h2 << 23, 32'h0, lat);
    chk("R6", "oldest pll OD=1", longint'(pll_o[2]), 288_000_000);
    chk("R8", "oldest apb OD=1", longint'(apb_o[2]), 48_000_000);

    // R7 strap table
    run_op("R7", 32'h0, 32'h0, 32'h0080_0300, lat);
    chk("R7", "table row25 idx3", longint'(pll_o[2]), 425_000_000);
    chk("R8", "table apb", longint'(apb_o[2]), 212_500_000);
    run_op("R7", 32'h0, 32'h0, 32'h0000_0200, lat);
    chk("R7", "table row24 idx2", longint'(pll_o[2]), 336_000_000);

    // R2 off bit
    run_op("R2", 32'h0088_8063, 32'h1 << 23, 32'h0, lat);
    for (int l = 0; l < NL; l++) begin
      chk("R2", "off pll", longint'(pll_o[l]), 0);
      chk("R2", "off apb", longint'(apb_o[l]), 0);
    end

    // R3 bypass
    run_op("R3", 32'h0108_8063, 32'h0, 32'h0, lat);
    chk("R3", "newer bypass", longint'(pll_o[0]), 25_000_000);
    chk("R3", "middle bypass", longint'(pll_o[1]), 24_000_000);
    run_op("R3", 32'h0100_0000, 32'h0, 32'h0000_0100, lat);
    chk("R3", "oldest bypass ignored unprogrammed", longint'(pll_o[2]), 360_000_000);
    run_op("R3", 32'h0300_02C1, 32'h0, 32'h0, lat);
    chk("R3", "oldest bypass programmed", longint'(pll_o[2]), 24_000_000);

    // R1 reference selection
    run_op("R1", 32'h0300_0000, 32'h0, 32'h1 << 18, lat);
    chk("R1", "48 MHz strap", longint'(pll_o[2]), 48_000_000);
    chk("R1", "forced 25 MHz", longint'(pll_o[0]), 25_000_000);
    run_op("R1", 32'h0300_0000, 32'h0, (32'h1 << 18) | (32'h1 << 23), lat);
    chk("R1", "25 over 48", longint'(pll_o[2]), 25_000_000);
    run_op("R1", 32'h0300_0000, 32'h0, 32'h0, lat);
    chk("R1", "default 24", longint'(pll_o[2]), 24_000_000);

    // R8 largest APB divider with truncation
    run_op("R8", 32'h0300_0000, 32'h7 << 23, 32'h0, lat);
    chk("R8", "oldest apb /16", longint'(apb_o[2]), 1_500_000);
    chk("R8", "middle apb /32", longint'(apb_o[1]), 750_000);
    run_op("R8", 32'h0100_0000, 32'h6 << 23, 32'h0, lat);
    chk("R8", "newer apb truncation", longint'(apb_o[0]), 892_857);

    // R10 start while busy is ignored, outputs hold afterwards
    @(negedge clk);
    cur_tag = "R10";
    pword = 32'h0008_8063;
    csel = 32'h1 << 23;
    strap = 32'h0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    pword = 32'h0100_0000;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done_o[0] && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    chk("R10", "busy start ignored", longint'(pll_o[0]), 250_000_000);
    held = longint'(pll_o[0]);
    pword = 32'h0;
    strap = 32'hFFFF_FFFF;
    repeat (LAT + 10) @(negedge clk);
    chk("R10", "output held", longint'(pll_o[0]), held);
    chk("R10", "no second done", longint'(done_o[0]), 0);

    // Random words checked against the model on every lane
    for (int i = 0; i < 24; i++) begin
      run_op("R4 R5 R6 R7 random", $urandom, $urandom, $urandom, lat);
      chk("R9", "random latency", lat, LAT + 1);
    end

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule